// File: doc/BRIEF.md
# Flash Instruction Serial Shift Engine

This block is the single-lane serial datapath of a master-mode flash controller. Software-side logic writes 32-bit words into a small transmit queue through one of four data port addresses. The address chosen tags each word with a length of one, two, three or four bytes, so a short flash instruction goes out without padding bytes. Once a start request arrives, the engine drains the transmit queue. It shifts each word out on one data line under a generated serial clock, and it samples the input line at the same time.

For every transmitted word, the engine pushes one received word with the same byte count into a receive queue, where it waits to be popped. The serial clock rate is the input clock divided by a power of two, taken from a three-bit field. Clock polarity and phase follow the four usual SPI modes. The active-low slave select lines are a registered copy of a configuration field.

Top module: `flash_shift_engine`

## Requirements
- R1: A write to port address 0x80 queues a 1-byte entry, 0x84 a 2-byte entry, 0x88 a 3-byte entry and 0x1C a 4-byte entry. A write to any other address queues nothing.
- R2: An entry of N bytes produces exactly 8N data bits on `mosi`. Byte 0 (bits 7:0) goes first, then the bytes at higher addresses, and within each byte bit 7 goes first.
- R3: While a word is shifting, successive `sclk` transitions are exactly 2^`cfg_baud` input clock cycles apart, so the serial clock period is 2 << `cfg_baud` cycles.
- R4: `cfg_cpol` sets the idle level of `sclk`. With `cfg_cpha` = 0, data is sampled on the first edge of each bit and changes on the second edge. With `cfg_cpha` = 1, data changes on the first edge and is sampled on the second.
- R5: `ss_n` equals the value of `cfg_ss_n` one cycle earlier, and it reads all ones after reset.
- R6: No serial clock edge occurs until `start_req` is pulsed. `busy` is high from the cycle after the pulse until the transmit queue is empty and the last bit has finished, and `busy` never falls while the transmit queue holds an entry.
- R7: Each transmitted entry yields one receive entry. Its `rx_bytes` equals the entry's length, its bytes are assembled in the same order as R2, and its unused upper bytes read zero.
- R8: While `busy` is low, `sclk` sits at the `cfg_cpol` level and `mosi` keeps its last value.
- R9: `tx_full` is high when the transmit queue holds its full depth of entries, and a write made while it is high is dropped.
- R10: No new entry starts shifting while the receive queue is full. The engine stays busy and resumes once an entry is popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data port write strobe |
| wr_addr | input | 8 | Data port address, selects entry length |
| wr_data | input | 32 | Word to queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| cfg_baud | input | 3 | Clock divider exponent n (divide by 2 << n) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase select |
| cfg_ss_n | input | 4 | Slave select pattern, active low |
| start_req | input | 1 | One-cycle start request pulse |
| busy | output | 1 | Transfer in progress |
| rx_pop | input | 1 | Remove the head receive entry |
| rx_valid | output | 1 | Receive queue holds an entry |
| rx_data | output | 32 | Head receive word |
| rx_bytes | output | 3 | Valid byte count of the head receive word (1 to 4) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Slave selects, active low |

## Verification
The bench builds the engine with both queue depths set to 4. With that depth, five writes are enough to overflow the transmit side, and four drained words are enough to fill the receive side, so the dropped-write case and the stall on a full receive queue both occur in a short run. The three-bit divider field keeps its full width, and the bench walks baud values 0 to 3 across the four clock modes, with the input line looped back inverted. The inversion means a sample taken on the wrong edge shows up as a wrong received word.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int WORD_W = 32;

  // Data port addresses; the address picks how many bytes the entry carries.
  localparam logic [7:0] PORT_WORD  = 8'h1C;
  localparam logic [7:0] PORT_BYTE1 = 8'h80;
  localparam logic [7:0] PORT_BYTE2 = 8'h84;
  localparam logic [7:0] PORT_BYTE3 = 8'h88;

  // lcode holds the byte count minus one.
  typedef struct packed {
    logic [1:0]        lcode;
    logic [WORD_W-1:0] data;
  } fse_entry_t;

  // Bit k of the serial stream maps to word position {byte, 7 - bit}.
  function automatic logic [4:0] bit_pos(input logic [4:0] k);
    return {k[4:3], ~k[2:0]};
  endfunction
endpackage

// File: rtl/fse_port_dec.sv
module fse_port_dec (
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  output logic       push,
  output logic [1:0] lcode
);
  import fse_pkg::*;

  always_comb begin
    push  = 1'b0;
    lcode = 2'd3;
    if (wr_en) begin
      case (wr_addr)
        PORT_BYTE1: begin push = 1'b1; lcode = 2'd0; end
        PORT_BYTE2: begin push = 1'b1; lcode = 2'd1; end
        PORT_BYTE3: begin push = 1'b1; lcode = 2'd2; end
        PORT_WORD:  begin push = 1'b1; lcode = 2'd3; end
        default:    begin push = 1'b0; lcode = 2'd3; end
      endcase
    end
  end
endmodule

// File: rtl/fse_fifo.sv
module fse_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/fse_clkdiv.sv
module fse_clkdiv #(
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic              clr,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  localparam int CW = 1 << BAUD_W;

  logic [CW-1:0] cnt_q, cnt_d, half_m1;

  assign half_m1 = (CW'(1) << baud) - CW'(1);
  assign tick    = en && (cnt_q == half_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fse_shifter.sv
module fse_shifter
  import fse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       start_req,
  input  logic       cfg_cpha,
  input  logic       tx_empty,
  input  fse_entry_t tx_entry,
  input  logic       rx_full,
  input  logic       tick,
  input  logic       miso,
  output logic       load,
  output logic       rx_push,
  output fse_entry_t rx_entry,
  output logic       active,
  output logic       busy,
  output logic       lvl,
  output logic       mosi
);
  logic              run_q, run_d, act_q, act_d, lvl_q, lvl_d, mosi_q, mosi_d;
  logic [4:0]        k_q, k_d, pos;
  logic [1:0]        lc_q, lc_d;
  logic [WORD_W-1:0] dat_q, dat_d, rxb_q, rxb_d, rx_bit;
  logic              last;

  assign pos    = bit_pos(k_q);
  assign last   = (k_q == {lc_q, 3'b111});
  assign load   = run_q && !act_q && !tx_empty && !rx_full;
  assign active = act_q;
  assign busy   = run_q;
  assign lvl    = lvl_q;
  assign mosi   = mosi_q;

  always_comb begin
    rx_bit      = rxb_q;
    rx_bit[pos] = miso;
  end

  assign rx_entry.lcode = lc_q;
  assign rx_entry.data  = cfg_cpha ? rx_bit : rxb_q;

  always_comb begin
    run_d   = run_q;
    act_d   = act_q;
    lvl_d   = lvl_q;
    k_d     = k_q;
    lc_d    = lc_q;
    dat_d   = dat_q;
    rxb_d   = rxb_q;
    mosi_d  = mosi_q;
    rx_push = 1'b0;

    if (start_req)                         run_d = 1'b1;
    else if (run_q && !act_q && tx_empty)  run_d = 1'b0;

    if (load) begin
      act_d = 1'b1;
      lvl_d = 1'b0;
      k_d   = '0;
      lc_d  = tx_entry.lcode;
      dat_d = tx_entry.data;
      rxb_d = '0;
      if (!cfg_cpha) mosi_d = tx_entry.data[7];
    end else if (act_q && tick) begin
      lvl_d = ~lvl_q;
      if (!lvl_q) begin
        // leading edge
        if (cfg_cpha) mosi_d = dat_q[pos];
        else          rxb_d  = rx_bit;
      end else begin
        // trailing edge
        if (cfg_cpha) rxb_d = rx_bit;
        if (last) begin
          act_d   = 1'b0;
          rx_push = 1'b1;
        end else begin
          k_d = k_q + 5'd1;
          if (!cfg_cpha) mosi_d = dat_q[bit_pos(k_q + 5'd1)];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      lvl_q  <= 1'b0;
      k_q    <= '0;
      lc_q   <= '0;
      dat_q  <= '0;
      rxb_q  <= '0;
      mosi_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      act_q  <= act_d;
      lvl_q  <= lvl_d;
      k_q    <= k_d;
      lc_q   <= lc_d;
      dat_q  <= dat_d;
      rxb_q  <= rxb_d;
      mosi_q <= mosi_d;
    end
  end
endmodule

// File: rtl/flash_shift_engine.sv
module flash_shift_engine #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int BAUD_W   = 3,
  parameter int SS_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [SS_W-1:0]   cfg_ss_n,
  input  logic              start_req,
  output logic              busy,
  input  logic              rx_pop,
  output logic              rx_valid,
  output logic [31:0]       rx_data,
  output logic [2:0]        rx_bytes,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_W-1:0]   ss_n
);
  import fse_pkg::*;

  localparam int ENTRY_W = $bits(fse_entry_t);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic       wr_push, tx_pop, rx_push, rx_full, rx_empty, load, active, tick, lvl;
  logic [1:0] wr_lcode;
  fse_entry_t tx_in, tx_head, rx_in, rx_head;
  logic [ENTRY_W-1:0] tx_head_v, rx_head_v;

  fse_port_dec u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .push(wr_push), .lcode(wr_lcode)
  );

  assign tx_in.lcode = wr_lcode;
  assign tx_in.data  = wr_data;

  fse_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_ni(rst_ni), .push(wr_push), .wdata(tx_in),
    .pop(tx_pop), .rdata(tx_head_v), .empty(tx_empty), .full(tx_full)
  );
  assign tx_head = fse_entry_t'(tx_head_v);
  assign tx_pop  = load;

  fse_clkdiv #(.BAUD_W(BAUD_W)) u_div (
    .clk(clk), .rst_ni(rst_ni), .en(active), .clr(load), .baud(cfg_baud), .tick(tick)
  );

  fse_shifter u_shf (
    .clk(clk), .rst_ni(rst_ni), .start_req(start_req), .cfg_cpha(cfg_cpha),
    .tx_empty(tx_empty), .tx_entry(tx_head), .rx_full(rx_full), .tick(tick),
    .miso(miso), .load(load), .rx_push(rx_push), .rx_entry(rx_in),
    .active(active), .busy(busy), .lvl(lvl), .mosi(mosi)
  );

  fse_fifo #(.W(ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_ni(rst_ni), .push(rx_push), .wdata(rx_in),
    .pop(rx_pop), .rdata(rx_head_v), .empty(rx_empty), .full(rx_full)
  );
  assign rx_head  = fse_entry_t'(rx_head_v);
  assign rx_valid = !rx_empty;
  assign rx_data  = rx_head.data;
  assign rx_bytes = {1'b0, rx_head.lcode} + 3'd1;

  assign sclk = lvl ^ cfg_cpol;

  logic [SS_W-1:0] ss_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ss_q <= '1;
    else         ss_q <= cfg_ss_n;
  end
  assign ss_n = ss_q;
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int SS_W = 4
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            busy,
  input logic            tx_empty,
  input logic            tx_full,
  input logic            sclk,
  input logic            mosi,
  input logic            cfg_cpol,
  input logic [SS_W-1:0] cfg_ss_n,
  input logic [SS_W-1:0] ss_n
);
  AST_SS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (ss_n == $past(cfg_ss_n))); // R5
  AST_BUSY_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> tx_empty); // R6
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (sclk == cfg_cpol)); // R8
  AST_IDLE_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> $stable(mosi)); // R8
  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_full && !busy) |=> tx_full); // R9
endmodule

bind flash_shift_engine fse_checker #(.SS_W(SS_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .busy(busy), .tx_empty(tx_empty),
  .tx_full(tx_full), .sclk(sclk), .mosi(mosi), .cfg_cpol(cfg_cpol),
  .cfg_ss_n(cfg_ss_n), .ss_n(ss_n)
);

// File: tb/flash_shift_engine_bench.sv
module flash_shift_engine_bench;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, wr_en, start_req, rx_pop, miso, inv;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data, rx_data;
  logic [2:0]  cfg_baud, rx_bytes;
  logic        cfg_cpol, cfg_cpha;
  logic [3:0]  cfg_ss_n, ss_n;
  logic        tx_full, tx_empty, busy, rx_valid, sclk, mosi;

  assign miso = mosi ^ inv;

  flash_shift_engine #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_flash_shift_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .cfg_baud(cfg_baud), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_ss_n(cfg_ss_n), .start_req(start_req), .busy(busy),
    .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bytes(rx_bytes),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Serial line monitor
  bit mlog [512];
  bit elog [512];
  int nlog = 0, nexp = 0, nedge = 0, gmin = 0, gmax = 0, last_e = 0, cyc = 0;
  logic sclk_prev = 1'b0;
  logic mon_clr = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      nlog = 0; nedge = 0; gmin = 1 << 30; gmax = 0;
    end else if (rst_n && sclk !== sclk_prev) begin
      if (nedge > 0) begin
        if (cyc - last_e < gmin) gmin = cyc - last_e;
        if (cyc - last_e > gmax) gmax = cyc - last_e;
      end
      last_e = cyc;
      nedge++;
      if (sclk == (cfg_cpha ? cfg_cpol : ~cfg_cpol)) begin
        if (nlog < 512) mlog[nlog] = mosi;
        nlog++;
      end
    end
    sclk_prev = sclk;
  end

  task automatic mon_clear();
    mon_clr = 1'b1;
    @(posedge clk); @(posedge clk);
    mon_clr = 1'b0;
    nexp = 0;
  endtask

  task automatic exp_add(input logic [31:0] d, input int nb);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) begin
        elog[nexp] = d[8*b+i];
        nexp++;
      end
  endtask

  task automatic cmp_log(input string req);
    int mism = 0;
    chk(nlog == nexp, req, 64'(nlog), 64'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++) if (mlog[i] != elog[i]) mism++;
    chk(mism == 0, req, 64'(mism), 64'd0);
  endtask

  function automatic logic [31:0] bmask(input int nb);
    return (nb >= 4) ? 32'hFFFFFFFF : ((32'h1 << (8*nb)) - 32'h1);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(1'b0, "R6 watchdog busy", 64'(busy), 64'd0);
  endtask

  task automatic pop_chk(input logic [31:0] ed, input int eb, input string req);
    @(negedge clk);
    chk(rx_valid == 1'b1, req, 64'(rx_valid), 64'd1);
    chk(rx_data == ed, req, 64'(rx_data), 64'(ed));
    chk(rx_bytes == 3'(eb), req, 64'(rx_bytes), 64'(eb));
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic [2:0] bd);
    @(negedge clk); cfg_cpol = pol; cfg_cpha = pha; cfg_baud = bd;
    @(negedge clk); @(negedge clk);
    mon_clear();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R6 reset busy", 64'(busy), 64'd0);
    chk(tx_empty == 1'b1, "R1 reset tx_empty", 64'(tx_empty), 64'd1);
    chk(rx_valid == 1'b0, "R7 reset rx_valid", 64'(rx_valid), 64'd0);
    chk(sclk == 1'b0, "R8 reset sclk", 64'(sclk), 64'd0);
    chk(ss_n == 4'hF, "R5 reset ss_n", 64'(ss_n), 64'hF);
  endtask

  task automatic t_ports();
    set_cfg(1'b0, 1'b0, 3'd0);
    inv = 1'b0;
    wr(8'h80, 32'hFFFFFFA5); exp_add(32'hFFFFFFA5, 1);
    wr(8'h84, 32'hFFFFC3E1); exp_add(32'hFFFFC3E1, 2);
    wr(8'h40, 32'hDEADBEEF);
    wr(8'h88, 32'hFF123456); exp_add(32'hFF123456, 3);
    wr(8'h1C, 32'h89ABCDEF); exp_add(32'h89ABCDEF, 4);
    start(); wait_idle();
    cmp_log("R1 R2 port lengths and bit order");
    pop_chk(32'h000000A5, 1, "R7 rx 1-byte");
    pop_chk(32'h0000C3E1, 2, "R7 rx 2-byte");
    pop_chk(32'h00123456, 3, "R7 rx 3-byte");
    pop_chk(32'h89ABCDEF, 4, "R7 rx 4-byte");
    @(negedge clk);
    chk(rx_valid == 1'b0, "R1 other address ignored", 64'(rx_valid), 64'd0);
  endtask

  task automatic t_nostart();
    set_cfg(1'b0, 1'b0, 3'd1);
    inv = 1'b0;
    wr(8'h1C, 32'h0F1E2D3C);
    repeat (40) @(negedge clk);
    chk(nedge == 0, "R6 no edges before start", 64'(nedge), 64'd0);
    chk(busy == 1'b0, "R6 idle before start", 64'(busy), 64'd0);
    chk(rx_valid == 1'b0, "R6 nothing received before start", 64'(rx_valid), 64'd0);
    start(); wait_idle();
    pop_chk(32'h0F1E2D3C, 4, "R6 runs after start");
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      logic [31:0] d;
      logic        mo;
      d = 32'h3C5A96E1 ^ (32'h01010101 * m);
      set_cfg(m[1], m[0], 3'(m));
      inv = 1'b1;
      wr(8'h1C, d); exp_add(d, 4);
      start(); wait_idle();
      cmp_log("R4 mode bit stream");
      chk(nedge == 64, "R4 edge count", 64'(nedge), 64'd64);
      chk(gmin == (1 << m) && gmax == (1 << m), "R3 half period",
          64'(gmax), 64'(1 << m));
      chk(sclk == m[1], "R8 idle level", 64'(sclk), 64'(m[1]));
      mo = mosi;
      repeat (20) @(negedge clk);
      chk(mosi == mo, "R8 mosi held", 64'(mosi), 64'(mo));
      pop_chk(~d, 4, "R4 R7 sampled inverted word");
    end
    inv = 1'b0;
  endtask

  task automatic t_ss();
    @(negedge clk); cfg_ss_n = 4'b1011;
    @(negedge clk);
    chk(ss_n == 4'b1011, "R5 select device 2", 64'(ss_n), 64'hB);
    cfg_ss_n = 4'hF;
    @(negedge clk);
    chk(ss_n == 4'hF, "R5 deselect all", 64'(ss_n), 64'hF);
  endtask

  task automatic t_full();
    set_cfg(1'b0, 1'b0, 3'd0);
    inv = 1'b0;
    for (int i = 0; i <= TXD; i++) wr(8'h1C, 32'h1000 + 32'(i));
    @(negedge clk);
    chk(tx_full == 1'b1, "R9 tx_full", 64'(tx_full), 64'd1);
    start(); wait_idle();
    wr(8'h1C, 32'h5555AAAA);
    start();
    repeat (60) @(negedge clk);
    chk(busy == 1'b1, "R10 stalled busy", 64'(busy), 64'd1);
    chk(tx_empty == 1'b0, "R10 entry held", 64'(tx_empty), 64'd0);
    pop_chk(32'h1000, 4, "R10 R9 first");
    wait_idle();
    for (int i = 1; i < TXD; i++) pop_chk(32'h1000 + 32'(i), 4, "R9 queued word");
    pop_chk(32'h5555AAAA, 4, "R9 R10 word after stall, overflow dropped");
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 no extra entry", 64'(rx_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; start_req = 1'b0;
    rx_pop = 1'b0; inv = 1'b0; cfg_baud = '0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_ss_n = 4'hF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ports();
    t_nostart();
    t_modes();
    t_ss();
    t_full();
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule